// File: doc/BRIEF.md
# Voltage-Frequency Transition Sequencer

This block takes one operating-point request from each of four cores and turns them into one operating point for the whole package, because all cores share a single supply. An operating point is a frequency ratio together with a voltage ID. The block then moves the package to that point in an order that is always safe. The voltage is raised before the clock speeds up, and the clock slows down before the voltage is lowered. Whenever the clock generator relocks, the block asserts a snoop-block output, and it holds that output for the whole relock window.

Each core writes its request through its own strobe. When a core writes a new request while a transition is already in progress, the block finishes the current transition first and only then starts working toward the new point. A programmable dwell count spaces out the voltage steps, which sets the ramp rate. A low-power mode can also be enabled. In that mode, an idle package drops to the lowest point, and it returns to the requested point when it wakes.

Top module: `vf_seq`

## Requirements
- R1: After reset, `cur_ratio` = MIN_RATIO and `cur_vid` = MIN_VID, every core request holds that lowest point, and `busy`, `snoop_block` and `lock_err` are 0.
- R2: The package target is the highest of the four requests. Points are ordered first by ratio and then by voltage ID, so {ratio, vid} is compared as one unsigned number. When all requests are equal, that common point is the target. When the transition ends, `cur_ratio` and `cur_vid` equal the target.
- R3: While the voltage ID is rising, it changes by exactly +1 per step. The first step comes `dwell_cfg`+1 cycles after the transition starts, and each later step comes `dwell_cfg`+1 cycles after the one before. All rising steps finish before `cur_ratio` changes.
- R4: While the voltage ID is falling, it changes by exactly -1 per step, spaced `dwell_cfg`+1 cycles apart. No falling step comes before the ratio change, when there is one.
- R5: `cur_ratio` changes only in the first cycle of a relock window. `snoop_block` is high from that cycle until the lock is accepted. `pll_lock` is ignored in the first cycle of the window, so when `pll_lock` is steadily high the window lasts exactly 2 cycles.
- R6: `busy` is high for the whole transition. The target is fixed when the transition starts. A request written during a transition does not change the point being reached, and it is started after `busy` falls.
- R7: When `lowpwr_en`=1 and `pkg_idle`=1, the target is the lowest point. When `pkg_idle` falls, the resolved request point becomes the target again. When `lowpwr_en`=0, `pkg_idle` has no effect.
- R8: If the lock is not accepted within TMO+1 cycles of the relock window, the window ends after TMO+1 cycles. `lock_err` is then set and stays set until reset, and the sequence continues.
- R9: `req_we[i]` loads only core i's register, from `req_ratio[i*RW +: RW]` and `req_vid[i*VW +: VW]`. A write that does not change the highest request starts no transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_we | input | NCORE | Per-core request write strobes |
| req_ratio | input | NCORE*RW | Per-core requested frequency ratio, core i at slice i*RW |
| req_vid | input | NCORE*VW | Per-core requested voltage ID, core i at slice i*VW |
| dwell_cfg | input | DW | Extra cycles between voltage ID steps |
| lowpwr_en | input | 1 | Enables the drop to the lowest point while idle |
| pkg_idle | input | 1 | Package idle indication |
| pll_lock | input | 1 | Clock generator lock indication |
| cur_ratio | output | RW | Current frequency ratio |
| cur_vid | output | VW | Current voltage ID |
| busy | output | 1 | Transition in progress |
| snoop_block | output | 1 | Cores unavailable, relock window |
| lock_err | output | 1 | Sticky lock timeout flag |

## Verification
The tests drive several kinds of transition and check a different property with each:
- **Rising both fields:** checks the ordering in which the voltage climbs first.
- **Falling both fields:** checks that the relock happens first.
- **Voltage-only moves, in each direction:** check that no relock window appears.
- **Unequal requests whose highest voltage ID sits on a lower ratio:** separate ratio-first ordering from a plain per-field maximum.
- **A lock held steadily high:** shows the blanked first cycle.
- **A dead lock:** shows the timeout path.
- **A request written mid-transition:** separates deferral from retargeting.
- **Idle with and without the low-power mode:** separate forced entry from a spurious drop.
- **A single-core write below the maximum:** shows that it has no effect.

// File: rtl/vf_seq.sv
module vf_seq #(
  parameter int NCORE     = 4,
  parameter int RW        = 6,
  parameter int VW        = 7,
  parameter int DW        = 8,
  parameter int TMO       = 1023,
  parameter int MIN_RATIO = 6,
  parameter int MIN_VID   = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NCORE-1:0]    req_we,
  input  logic [NCORE*RW-1:0] req_ratio,
  input  logic [NCORE*VW-1:0] req_vid,
  input  logic [DW-1:0]       dwell_cfg,
  input  logic                lowpwr_en,
  input  logic                pkg_idle,
  input  logic                pll_lock,
  output logic [RW-1:0]       cur_ratio,
  output logic [VW-1:0]       cur_vid,
  output logic                busy,
  output logic                snoop_block,
  output logic                lock_err
);
  localparam int PW = RW + VW;
  localparam int TW = $clog2(TMO + 1);
  localparam int CW = (TW > DW) ? TW : DW;
  localparam logic [RW-1:0] LO_R = RW'(MIN_RATIO);
  localparam logic [VW-1:0] LO_V = VW'(MIN_VID);

  typedef enum logic [1:0] {S_IDLE, S_RAISE, S_RELOCK, S_LOWER} st_t;
  st_t st;

  logic [RW-1:0] rq_r [NCORE];
  logic [VW-1:0] rq_v [NCORE];
  logic [PW-1:0] best, eff;
  logic [RW-1:0] eff_r, tgt_r;
  logic [VW-1:0] eff_v, tgt_v;
  logic [CW-1:0] cnt;
  logic          dwell_hit, tmo_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCORE; i++) begin
        rq_r[i] <= LO_R;
        rq_v[i] <= LO_V;
      end
    end else begin
      for (int i = 0; i < NCORE; i++) begin
        if (req_we[i]) begin
          rq_r[i] <= req_ratio[i*RW +: RW];
          rq_v[i] <= req_vid[i*VW +: VW];
        end
      end
    end
  end

  always_comb begin
    best = {rq_r[0], rq_v[0]};
    for (int i = 1; i < NCORE; i++)
      if ({rq_r[i], rq_v[i]} > best) best = {rq_r[i], rq_v[i]};
  end

  assign eff       = (lowpwr_en && pkg_idle) ? {LO_R, LO_V} : best;
  assign eff_r     = eff[PW-1:VW];
  assign eff_v     = eff[VW-1:0];
  assign dwell_hit = (cnt == CW'(dwell_cfg));
  assign tmo_hit   = (cnt == CW'(TMO));
  assign busy        = (st != S_IDLE);
  assign snoop_block = (st == S_RELOCK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cur_ratio <= LO_R;
      cur_vid   <= LO_V;
      tgt_r     <= LO_R;
      tgt_v     <= LO_V;
      cnt       <= '0;
      lock_err  <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          cnt <= '0;
          if (eff != {cur_ratio, cur_vid}) begin
            tgt_r <= eff_r;
            tgt_v <= eff_v;
            if (eff_v > cur_vid) st <= S_RAISE;
            else if (eff_r != cur_ratio) begin
              st        <= S_RELOCK;
              cur_ratio <= eff_r;
            end else st <= S_LOWER;
          end
        end
        S_RAISE: begin
          if (cur_vid == tgt_v) begin
            cnt <= '0;
            if (tgt_r != cur_ratio) begin
              st        <= S_RELOCK;
              cur_ratio <= tgt_r;
            end else st <= S_IDLE;
          end else if (dwell_hit) begin
            cur_vid <= cur_vid + 1'b1;
            cnt     <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_RELOCK: begin
          if (cnt != '0 && pll_lock) begin
            cnt <= '0;
            st  <= (tgt_v < cur_vid) ? S_LOWER : S_IDLE;
          end else if (tmo_hit) begin
            lock_err <= 1'b1;
            cnt      <= '0;
            st       <= (tgt_v < cur_vid) ? S_LOWER : S_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        S_LOWER: begin
          if (cur_vid == tgt_v) st <= S_IDLE;
          else if (dwell_hit) begin
            cur_vid <= cur_vid - 1'b1;
            cnt     <= '0;
          end else cnt <= cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_vid_unit_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_vid) |-> ((cur_vid - $past(cur_vid)) == VW'(1) ||
                           ($past(cur_vid) - cur_vid) == VW'(1)));

  p_ratio_in_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_ratio) |-> snoop_block);

  p_vid_quiet_in_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_block |-> $stable(cur_vid));

  p_window_in_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_block |-> busy);

  p_target_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(tgt_r) && $stable(tgt_v)));

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lock_err |=> lock_err);
endmodule

// File: tb/vf_seq_tb_top.sv
module vf_seq_tb_top;
  localparam int TMO_T = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  req_we = '0;
  logic [23:0] req_ratio = '0;
  logic [27:0] req_vid = '0;
  logic [7:0]  dwell_cfg = '0;
  logic        lowpwr_en = 1'b0;
  logic        pkg_idle = 1'b0;
  logic        pll_lock = 1'b1;
  logic [5:0]  cur_ratio;
  logic [6:0]  cur_vid;
  logic        busy, snoop_block, lock_err;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int pll_mode = 0;
  int lcnt = 0;
  logic [5:0] prev_r = 6'd6;

  vf_seq #(.TMO(TMO_T)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_we(req_we), .req_ratio(req_ratio),
    .req_vid(req_vid), .dwell_cfg(dwell_cfg), .lowpwr_en(lowpwr_en),
    .pkg_idle(pkg_idle), .pll_lock(pll_lock), .cur_ratio(cur_ratio),
    .cur_vid(cur_vid), .busy(busy), .snoop_block(snoop_block),
    .lock_err(lock_err));

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (cur_ratio != prev_r) begin
      prev_r   = cur_ratio;
      pll_lock = (pll_mode == 1);
      lcnt     = 5;
    end else if (pll_mode == 0 && lcnt > 0) begin
      lcnt--;
      if (lcnt == 0) pll_lock = 1'b1;
    end else if (pll_mode == 1) pll_lock = 1'b1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic put(input int c, input logic [5:0] r, input logic [6:0] v);
    req_ratio[c*6 +: 6] = r;
    req_vid[c*7 +: 7]   = v;
  endtask

  task automatic strobe(input logic [3:0] we);
    req_we = we;
    @(negedge clk);
    req_we = '0;
  endtask

  task automatic wr_all(input logic [5:0] r, input logic [6:0] v);
    for (int c = 0; c < 4; c++) put(c, r, v);
    strobe(4'hf);
  endtask

  task automatic quiet(input int n, input string tag);
    logic [5:0] r0;
    logic [6:0] v0;
    bit moved;
    r0 = cur_ratio;
    v0 = cur_vid;
    moved = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (busy || cur_ratio != r0 || cur_vid != v0) moved = 1;
    end
    chk(!moved, tag, moved, 0);
  endtask

  task automatic watch(input logic [5:0] er, input logic [6:0] ev, input int dw,
                       input bit gap_chk, input bit exp_err, output int win);
    logic [5:0] sr, pr;
    logic [6:0] sv, pv, vtop;
    bit started, moved, pre_snoop, done;
    int since, waitn;
    sr = cur_ratio; sv = cur_vid; pr = sr; pv = sv;
    vtop = (ev > sv) ? ev : sv;
    started = 0; moved = 0; pre_snoop = 0; done = 0;
    since = 0; waitn = 0; win = 0;
    while (!done) begin
      @(negedge clk);
      if (!started) begin
        if (!busy) begin
          waitn++;
          if (waitn > 20) begin
            chk(0, "R6 transition start", 0, 1);
            return;
          end
          continue;
        end
        started = 1;
        since = 0;
      end else since++;
      if (pre_snoop && !snoop_block) since = 0;
      if (cur_vid != pv) begin
        chk(cur_vid == pv + 7'd1 || cur_vid == pv - 7'd1, "R3 R4 unit step", cur_vid, pv);
        if (cur_vid > pv) chk(!moved, "R3 raise before relock", moved, 0);
        else chk(moved || er == sr, "R4 lower after relock", moved, 1);
        if (gap_chk) chk(since == dw + 1, "R3 R4 step spacing", since, dw + 1);
        since = 0;
      end
      if (cur_ratio != pr) begin
        chk(snoop_block == 1'b1, "R5 ratio inside window", snoop_block, 1);
        chk(cur_vid == vtop, "R3 voltage up first", cur_vid, vtop);
        moved = 1;
      end
      if (snoop_block) win++;
      pre_snoop = snoop_block;
      pr = cur_ratio;
      pv = cur_vid;
      if (!busy) done = 1;
    end
    chk(cur_ratio == er, "R2 final ratio", cur_ratio, er);
    chk(cur_vid == ev, "R2 final vid", cur_vid, ev);
    chk(lock_err == exp_err, "R8 lock_err", lock_err, exp_err);
  endtask

  task automatic t_reset;
    chk(cur_ratio == 6'd6, "R1 reset ratio", cur_ratio, 6);
    chk(cur_vid == 7'd20, "R1 reset vid", cur_vid, 20);
    chk(!busy && !snoop_block && !lock_err, "R1 reset flags",
        {busy, snoop_block, lock_err}, 0);
    quiet(8, "R1 idle after reset");
  endtask

  task automatic t_up_common;
    int w;
    dwell_cfg = 8'd2;
    wr_all(6'd12, 7'd28);
    watch(6'd12, 7'd28, 2, 1, 0, w);
    chk(w >= 2, "R5 window present", w, 2);
  endtask

  task automatic t_steady_lock;
    int w;
    pll_mode = 1;
    dwell_cfg = 8'd0;
    wr_all(6'd13, 7'd29);
    watch(6'd13, 7'd29, 0, 1, 0, w);
    chk(w == 2, "R5 lock blanking window", w, 2);
    pll_mode = 0;
  endtask

  task automatic t_mixed;
    int w;
    dwell_cfg = 8'd1;
    put(0, 6'd10, 7'd24);
    put(1, 6'd14, 7'd30);
    put(2, 6'd9,  7'd40);
    put(3, 6'd14, 7'd26);
    strobe(4'hf);
    watch(6'd14, 7'd30, 1, 1, 0, w);
  endtask

  task automatic t_single_core;
    int w;
    put(2, 6'd8, 7'd22);
    strobe(4'b0100);
    quiet(10, "R9 lower single write ignored");
    put(1, 6'd8, 7'd22);
    put(3, 6'd8, 7'd22);
    strobe(4'b1010);
    watch(6'd10, 7'd24, 1, 1, 0, w);
  endtask

  task automatic t_down;
    int w;
    dwell_cfg = 8'd3;
    wr_all(6'd7, 7'd21);
    watch(6'd7, 7'd21, 3, 1, 0, w);
  endtask

  task automatic t_vid_only;
    int w;
    dwell_cfg = 8'd1;
    wr_all(6'd7, 7'd25);
    watch(6'd7, 7'd25, 1, 1, 0, w);
    chk(w == 0, "R3 no window on vid-only raise", w, 0);
    wr_all(6'd7, 7'd23);
    watch(6'd7, 7'd23, 1, 1, 0, w);
    chk(w == 0, "R4 no window on vid-only lower", w, 0);
  endtask

  task automatic t_defer;
    int w;
    dwell_cfg = 8'd1;
    wr_all(6'd14, 7'd30);
    while (!busy) @(negedge clk);
    for (int c = 0; c < 4; c++) put(c, 6'd8, 7'd22);
    strobe(4'hf);
    watch(6'd14, 7'd30, 1, 0, 0, w);
    watch(6'd8, 7'd22, 1, 1, 0, w);
    chk(cur_ratio == 6'd8, "R6 deferred request applied", cur_ratio, 8);
  endtask

  task automatic t_lowpower;
    int w;
    dwell_cfg = 8'd0;
    wr_all(6'd12, 7'd28);
    watch(6'd12, 7'd28, 0, 1, 0, w);
    lowpwr_en = 1'b0;
    pkg_idle  = 1'b1;
    quiet(10, "R7 idle ignored when disabled");
    lowpwr_en = 1'b1;
    watch(6'd6, 7'd20, 0, 1, 0, w);
    pkg_idle = 1'b0;
    watch(6'd12, 7'd28, 0, 1, 0, w);
    lowpwr_en = 1'b0;
  endtask

  task automatic t_timeout;
    int w;
    pll_mode = 2;
    dwell_cfg = 8'd0;
    wr_all(6'd9, 7'd24);
    watch(6'd9, 7'd24, 0, 1, 1, w);
    chk(w == TMO_T + 1, "R8 timeout window", w, TMO_T + 1);
    quiet(5, "R8 error stays");
    chk(lock_err == 1'b1, "R8 sticky", lock_err, 1);
  endtask

  initial begin
    for (int c = 0; c < 4; c++) put(c, 6'd6, 7'd20);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_up_common();
    t_steady_lock();
    t_mixed();
    t_single_core();
    t_down();
    t_vid_only();
    t_defer();
    t_lowpower();
    t_timeout();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule